// File: doc/BRIEF.md
# Waveform Charge Integrator with Per-Channel Event Buffers

This block turns a stretch of digitised waveform into a charge value for each of several channels. A stop trigger freezes an analog sample store upstream. The samples are then read back through an ADC and reach the block as one parallel word per clock, with a valid strobe. The block discards a configurable number of leading samples to reach the window of interest. It then takes a configurable number of samples and subtracts a per-channel pedestal from each one. The signed differences are summed into a charge word.

Each channel writes its result into its own event buffer as a self-describing record. A record is a header word, then the raw samples if waveform output is enabled, then the charge word. A record can be withheld when its charge falls below a threshold. Records become visible to the readout side only once they are complete, so a reader never sees half an event. A busy output covers the read-out window. It also stays high while any buffer lacks space for one more full record, so triggers arriving then are refused.

Top module: `qdc_wave_integrator`

## Requirements
- R1: After reset, busy is low and no channel offers a word (all out_valid low).
- R2: A trigger seen while busy is low starts an event. Busy is high from the next cycle. With a sample on every cycle, busy stays high for skip+N+2 cycles in total.
- R3: After an accepted trigger, the first cfg_skip valid samples are discarded and the next N valid samples are used. Cycles with smp_valid low are not counted, and samples after the N-th are ignored.
- R4: The charge is the sum over the N used samples of (sample − pedestal), with the pedestal taken per channel. It is stored as the word {2'b01, charge sign-extended to 30 bits}.
- R5: With cfg_wave_en high, the N used samples are stored in arrival order as {2'b00, zero-extended sample}, between the header and the charge word. With cfg_wave_en low, only the charge word follows the header.
- R6: Every record starts with the header {2'b10, channel[3:0], event number[13:0], word count[11:0]}. The word count is the number of words after the header: N+1 with waveform output, 1 without.
- R7: With cfg_zs_en high, a channel whose charge is below cfg_zs_thr (signed compare) stores nothing for that event. A charge equal to the threshold is kept. Other channels are unaffected.
- R8: A trigger is refused, and busy is held high, while any channel buffer has fewer free words than the record size for the present settings (N+2 with waveform output, otherwise 2). Busy falls once the buffers are drained.
- R9: Records from several events queue in each buffer and leave in order, one word per cycle when out_valid and out_ready are both high. A word held with out_ready low stays unchanged.
- R10: A sample count of 0 is treated as 1, and a count above MAXN is treated as MAXN.
- R11: The event number starts at 0 after reset and increases by one for every accepted trigger, including events that zero suppression drops on some channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample word valid |
| smp_data | input | NCH*SW | One unsigned sample per channel, channel 0 in the low bits |
| trig | input | 1 | Stop trigger, starts an event when busy is low |
| busy | output | 1 | Event in progress or a buffer lacks room |
| cfg_nsamp | input | NW | Samples to integrate (N) |
| cfg_skip | input | NW | Valid samples discarded before the window |
| cfg_wave_en | input | 1 | Store raw samples as well as the charge |
| cfg_zs_en | input | 1 | Enable zero suppression |
| cfg_zs_thr | input | AW | Signed suppression threshold |
| cfg_pedestal | input | NCH*SW | Per-channel pedestal |
| out_valid | output | NCH | Per-channel word available |
| out_ready | input | NCH | Per-channel word accepted |
| out_data | output | NCH*32 | Per-channel record words |

## Verification
The bench builds the block with two channels, 8-bit samples, a 16-word buffer and MAXN of 8. At these settings one full waveform record of eight samples takes ten words. That leaves less room than a second record needs, so the refuse-and-hold behaviour is reached with a single event. An eight-sample sum of maximum-size differences comes within a few counts of the 12-bit accumulator limit, and a requested count of 14 exercises the upper clamp. A pedestal of 255 makes negative charges easy to produce, which lets the bench test sign extension and the suppression threshold on both sides, including equality.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  localparam int QW = 32;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_CHARGE  = 2'd2,
    ST_HEADER  = 2'd3
  } qdc_state_e;

  localparam logic [1:0] TAG_SAMPLE = 2'b00;
  localparam logic [1:0] TAG_CHARGE = 2'b01;
  localparam logic [1:0] TAG_HEADER = 2'b10;

  // record header: tag, channel, event number, words that follow
  function automatic logic [QW-1:0] pack_header(input logic [3:0] ch,
                                                 input logic [13:0] evt,
                                                 input logic [11:0] cnt);
    return {TAG_HEADER, ch, evt, cnt};
  endfunction

  function automatic logic [QW-1:0] pack_charge(input logic [29:0] q);
    return {TAG_CHARGE, q};
  endfunction

  function automatic logic [QW-1:0] pack_sample(input logic [29:0] s);
    return {TAG_SAMPLE, s};
  endfunction
endpackage

// File: rtl/qdc_evfifo.sv
module qdc_evfifo import qdc_pkg::*; #(
  parameter int DEPTH = 512,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [QW-1:0] wdata,
  input  logic          commit,
  input  logic [PW:0]   commit_len,
  output logic [PW-1:0] wptr,
  output logic [PW:0]   free,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [QW-1:0] out_data
);
  logic [QW-1:0] mem [DEPTH];
  logic [PW:0]   wp, rp;
  logic [PW:0]   level;
  logic          pop;

  assign level     = wp - rp;
  assign free      = (PW+1)'(DEPTH) - level;
  assign wptr      = wp[PW-1:0];
  assign out_valid = (wp != rp);
  assign out_data  = mem[rp[PW-1:0]];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (commit) wp <= wp + commit_len;
      if (pop)    rp <= rp + (PW+1)'(1);
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);

  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/qdc_ctrl.sv
module qdc_ctrl import qdc_pkg::*; #(
  parameter int MAXN = 1024,
  parameter int NW   = $clog2(MAXN+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic          trig,
  input  logic [NW-1:0] cfg_nsamp,
  input  logic [NW-1:0] cfg_skip,
  input  logic          cfg_wave_en,
  input  logic          all_room,
  output logic          busy,
  output logic          ev_start,
  output logic          take,
  output logic          ph_charge,
  output logic          ph_header,
  output logic [NW-1:0] cur_n,
  output logic          cur_wf,
  output logic [13:0]   evt_num,
  output logic [NW+1:0] need
);
  function automatic logic [NW-1:0] clamp_n(input logic [NW-1:0] n);
    if (n == '0) return NW'(1);
    if (32'(n) > MAXN) return NW'(MAXN);
    return n;
  endfunction

  function automatic logic [NW+1:0] need_words(input logic [NW-1:0] n, input logic wf);
    return wf ? ((NW+2)'(n) + (NW+2)'(2)) : (NW+2)'(2);
  endfunction

  qdc_state_e    state;
  logic [NW-1:0] cur_skip, skip_cnt, take_cnt;
  logic          skip_step, last_take;

  assign busy      = (state != ST_IDLE) || !all_room;
  assign ev_start  = trig && !busy;
  assign take      = (state == ST_COLLECT) && smp_valid && (skip_cnt == cur_skip);
  assign skip_step = (state == ST_COLLECT) && smp_valid && (skip_cnt != cur_skip);
  assign last_take = take && (take_cnt == cur_n - NW'(1));
  assign ph_charge = (state == ST_CHARGE);
  assign ph_header = (state == ST_HEADER);
  assign need      = need_words(clamp_n(cfg_nsamp), cfg_wave_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_n    <= NW'(1);
      cur_wf   <= 1'b0;
      cur_skip <= '0;
      skip_cnt <= '0;
      take_cnt <= '0;
      evt_num  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ev_start) begin
          state    <= ST_COLLECT;
          cur_n    <= clamp_n(cfg_nsamp);
          cur_wf   <= cfg_wave_en;
          cur_skip <= cfg_skip;
          skip_cnt <= '0;
          take_cnt <= '0;
        end
        ST_COLLECT: begin
          if (skip_step) skip_cnt <= skip_cnt + NW'(1);
          if (take)      take_cnt <= take_cnt + NW'(1);
          if (last_take) state    <= ST_CHARGE;
        end
        ST_CHARGE: state <= ST_HEADER;
        ST_HEADER: begin
          evt_num <= evt_num + 14'd1;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> busy);

  p_refuse_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy && state == ST_IDLE) |=> (state == ST_IDLE));

  p_take_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph_charge |-> (take_cnt == cur_n));

  p_evt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ph_header |=> (evt_num == $past(evt_num) + 14'd1));
endmodule

// File: rtl/qdc_chan.sv
module qdc_chan import qdc_pkg::*; #(
  parameter int CH_ID = 0,
  parameter int SW    = 14,
  parameter int AW    = 25,
  parameter int NW    = 11,
  parameter int DEPTH = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SW-1:0]        smp,
  input  logic [SW-1:0]        ped,
  input  logic                 ev_start,
  input  logic                 take,
  input  logic                 ph_charge,
  input  logic                 ph_header,
  input  logic [NW-1:0]        cur_n,
  input  logic                 cur_wf,
  input  logic [13:0]          evt_num,
  input  logic                 zs_en,
  input  logic signed [AW-1:0] zs_thr,
  input  logic [NW+1:0]        need,
  output logic                 room,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [QW-1:0]        out_data
);
  localparam int PW = $clog2(DEPTH);

  // pedestal-corrected sample, sign-extended to accumulator width
  function automatic logic signed [AW-1:0] ped_diff(input logic [SW-1:0] s,
                                                    input logic [SW-1:0] p);
    logic signed [SW:0] d;
    d = $signed({1'b0, s}) - $signed({1'b0, p});
    return {{(AW-SW-1){d[SW]}}, d};
  endfunction

  function automatic logic [29:0] charge30(input logic signed [AW-1:0] q);
    return {{(30-AW){q[AW-1]}}, q};
  endfunction

  logic [PW-1:0]        tmp_ptr;
  logic signed [AW-1:0] acc;
  logic                 keep;
  logic [PW-1:0]        wptr;
  logic [PW:0]          free;
  logic [NW:0]          wcount;
  logic                 we, commit;
  logic [PW-1:0]        waddr;
  logic [QW-1:0]        wdata;
  logic [PW:0]          commit_len;

  assign wcount     = cur_wf ? ((NW+1)'(cur_n) + (NW+1)'(1)) : (NW+1)'(1);
  assign commit     = ph_header && keep;
  assign commit_len = (PW+1)'(wcount) + (PW+1)'(1);
  assign room       = (32'(free) >= 32'(need));

  always_comb begin
    we    = 1'b0;
    waddr = tmp_ptr;
    wdata = pack_sample(30'(smp));
    if (take && cur_wf) begin
      we = 1'b1;
    end else if (ph_charge) begin
      we    = 1'b1;
      wdata = pack_charge(charge30(acc));
    end else if (commit) begin
      we    = 1'b1;
      waddr = wptr;
      wdata = pack_header(4'(CH_ID), evt_num, 12'(wcount));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmp_ptr <= '0;
      acc     <= '0;
      keep    <= 1'b0;
    end else begin
      if (ev_start) begin
        acc     <= '0;
        tmp_ptr <= wptr + PW'(1);
      end
      if (take) begin
        acc <= acc + ped_diff(smp, ped);
        if (cur_wf) tmp_ptr <= tmp_ptr + PW'(1);
      end
      if (ph_charge) keep <= !(zs_en && (acc < zs_thr));
    end
  end

  qdc_evfifo #(.DEPTH(DEPTH)) i_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (we),
    .waddr      (waddr),
    .wdata      (wdata),
    .commit     (commit),
    .commit_len (commit_len),
    .wptr       (wptr),
    .free       (free),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data)
  );

  p_commit_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !(out_valid && out_ready)) |=> (free == $past(free) - $past(commit_len)));
endmodule

// File: rtl/qdc_wave_integrator.sv
module qdc_wave_integrator import qdc_pkg::*; #(
  parameter int NCH   = 4,
  parameter int SW    = 14,
  parameter int DEPTH = 512,
  parameter int MAXN  = 1024,
  localparam int NW   = $clog2(MAXN+1),
  localparam int AW   = SW + 1 + $clog2(MAXN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [NCH*SW-1:0]    smp_data,
  input  logic                 trig,
  output logic                 busy,
  input  logic [NW-1:0]        cfg_nsamp,
  input  logic [NW-1:0]        cfg_skip,
  input  logic                 cfg_wave_en,
  input  logic                 cfg_zs_en,
  input  logic signed [AW-1:0] cfg_zs_thr,
  input  logic [NCH*SW-1:0]    cfg_pedestal,
  output logic [NCH-1:0]       out_valid,
  input  logic [NCH-1:0]       out_ready,
  output logic [NCH*QW-1:0]    out_data
);
  logic          ev_start, take, ph_charge, ph_header, cur_wf, all_room;
  logic [NW-1:0] cur_n;
  logic [13:0]   evt_num;
  logic [NW+1:0] need;
  logic [NCH-1:0] room_vec;

  assign all_room = &room_vec;

  qdc_ctrl #(.MAXN(MAXN), .NW(NW)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .trig       (trig),
    .cfg_nsamp  (cfg_nsamp),
    .cfg_skip   (cfg_skip),
    .cfg_wave_en(cfg_wave_en),
    .all_room   (all_room),
    .busy       (busy),
    .ev_start   (ev_start),
    .take       (take),
    .ph_charge  (ph_charge),
    .ph_header  (ph_header),
    .cur_n      (cur_n),
    .cur_wf     (cur_wf),
    .evt_num    (evt_num),
    .need       (need)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qdc_chan #(.CH_ID(c), .SW(SW), .AW(AW), .NW(NW), .DEPTH(DEPTH)) i_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp       (smp_data[c*SW +: SW]),
      .ped       (cfg_pedestal[c*SW +: SW]),
      .ev_start  (ev_start),
      .take      (take),
      .ph_charge (ph_charge),
      .ph_header (ph_header),
      .cur_n     (cur_n),
      .cur_wf    (cur_wf),
      .evt_num   (evt_num),
      .zs_en     (cfg_zs_en),
      .zs_thr    (cfg_zs_thr),
      .need      (need),
      .room      (room_vec[c]),
      .out_valid (out_valid[c]),
      .out_ready (out_ready[c]),
      .out_data  (out_data[c*QW +: QW])
    );
  end
endmodule

// File: tb/test_qdc_wave_integrator.sv
module test_qdc_wave_integrator;
  localparam int NCH = 2, SW = 8, DEPTH = 16, MAXN = 8, NW = 4, AW = 12;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst_n, smp_valid, trig, busy, cfg_wave_en, cfg_zs_en;
  logic [NCH*SW-1:0]    smp_data, cfg_pedestal;
  logic [NW-1:0]        cfg_nsamp, cfg_skip;
  logic signed [AW-1:0] cfg_zs_thr;
  logic [NCH-1:0]       out_valid, out_ready;
  logic [NCH*32-1:0]    out_data;

  qdc_wave_integrator #(.NCH(NCH), .SW(SW), .DEPTH(DEPTH), .MAXN(MAXN)) i_qdc_wave_integrator (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data), .trig(trig),
    .busy(busy), .cfg_nsamp(cfg_nsamp), .cfg_skip(cfg_skip), .cfg_wave_en(cfg_wave_en),
    .cfg_zs_en(cfg_zs_en), .cfg_zs_thr(cfg_zs_thr), .cfg_pedestal(cfg_pedestal),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  int checks = 0, failures = 0, evt_cnt = 0;
  bit done = 1'b0;
  logic [31:0] expq [NCH][64];
  int qh [NCH];
  int qt [NCH];

  // fields: n, wf, skip, zs, thr, ped0, ped1, base, step, gap
  localparam int VEC [6][10] = '{
    '{ 4, 1, 0, 0,     0,  10,  20,  50,  3, 0},
    '{ 8, 0, 2, 0,     0,   0, 255, 200,  5, 1},
    '{ 3, 1, 1, 1,     0,   5, 250, 100,  1, 0},
    '{ 0, 1, 0, 0,     0,   0,   0,   7,  0, 0},
    '{ 6, 1, 3, 1, -2000, 100,   0,  30, 40, 1},
    '{14, 0, 0, 0,     0, 128, 128,   0, 31, 0}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int smp_val(int base, int step, int j, int c);
    return (base + j*step + c*37) % 256;
  endfunction

  task automatic push(int c, logic [31:0] w);
    expq[c][qt[c] % 64] = w;
    qt[c]++;
  endtask

  function automatic logic [31:0] hdr(int c, int evt, int wc);
    return {2'b10, 4'(c), 14'(evt), 12'(wc)};
  endfunction

  function automatic logic [31:0] chg(int q);
    return {2'b01, 30'(q)};
  endfunction

  task automatic run_event(int n, int wf, int skip, int zs, int thr, int ped0, int ped1,
                           int base, int step, int gap, bit accept);
    int neff, q, s;
    neff = (n == 0) ? 1 : ((n > MAXN) ? MAXN : n);
    @(negedge clk);
    cfg_nsamp = NW'(n); cfg_skip = NW'(skip); cfg_wave_en = wf[0]; cfg_zs_en = zs[0];
    cfg_zs_thr = AW'(thr); cfg_pedestal = {8'(ped1), 8'(ped0)};
    trig = 1'b1; smp_valid = 1'b0;
    @(negedge clk);
    trig = 1'b0;
    for (int j = 0; j < skip + neff; j++) begin
      if (gap != 0 && j == 1) begin
        smp_valid = 1'b0; smp_data = '1;
        @(negedge clk);
      end
      smp_valid = 1'b1;
      smp_data = {8'(smp_val(base, step, j, 1)), 8'(smp_val(base, step, j, 0))};
      @(negedge clk);
    end
    smp_data = 16'h0F0F;               // trailing samples must be ignored (R3)
    repeat (2) @(negedge clk);
    smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    if (accept) begin
      for (int c = 0; c < NCH; c++) begin
        q = 0;
        for (int j = skip; j < skip + neff; j++)
          q += smp_val(base, step, j, c) - ((c == 0) ? ped0 : ped1);
        if (zs == 0 || q >= thr) begin
          push(c, hdr(c, evt_cnt, (wf != 0) ? neff + 1 : 1));
          if (wf != 0)
            for (int j = skip; j < skip + neff; j++) begin
              s = smp_val(base, step, j, c);
              push(c, 32'(s));
            end
          push(c, chg(q));
        end
      end
      evt_cnt++;
    end
  endtask

  task automatic drain(int c, string req);
    int guard;
    logic [31:0] first;
    guard = 0;
    if (out_valid[c]) begin          // stall one cycle with ready low (R9)
      first = out_data[c*32 +: 32];
      @(negedge clk);
      check(out_valid[c] && out_data[c*32 +: 32] == first, "R9 stall hold",
            out_data[c*32 +: 32], first);
    end
    while (out_valid[c] && guard < 64) begin
      if (qh[c] == qt[c]) begin
        check(1'b0, {req, " unexpected word"}, out_data[c*32 +: 32], 0);
      end else begin
        check(out_data[c*32 +: 32] == expq[c][qh[c] % 64], req,
              out_data[c*32 +: 32], expq[c][qh[c] % 64]);
        qh[c]++;
      end
      out_ready[c] = 1'b1;
      @(negedge clk);
      out_ready[c] = 1'b0;
      guard++;
    end
    check(qh[c] == qt[c], {req, " record complete"}, qh[c], qt[c]);
    qh[c] = qt[c];
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int cnt;
    rst_n = 1'b0; smp_valid = 1'b0; trig = 1'b0; smp_data = '0;
    cfg_nsamp = '0; cfg_skip = '0; cfg_wave_en = 1'b0; cfg_zs_en = 1'b0;
    cfg_zs_thr = '0; cfg_pedestal = '0; out_ready = '0;
    for (int c = 0; c < NCH; c++) begin qh[c] = 0; qt[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(out_valid == '0, "R1 out_valid after reset", out_valid, 0);

    // table walk: R3 R4 R5 R6 R7 R10 R11
    for (int v = 0; v < 6; v++) begin
      run_event(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                VEC[v][6], VEC[v][7], VEC[v][8], VEC[v][9], 1'b1);
      drain(0, "R4 R5 R6 R7 R10 ch0");
      drain(1, "R4 R5 R6 R7 R10 ch1");
      check(busy == 1'b0, "R8 busy idle after drain", busy, 0);
    end

    // R2: busy window with continuous samples, skip=2, N=5
    @(negedge clk);
    cfg_nsamp = 4'd5; cfg_skip = 4'd2; cfg_wave_en = 1'b0; cfg_zs_en = 1'b0;
    cfg_pedestal = '0; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0; smp_valid = 1'b1; smp_data = 16'h0302;
    cnt = 0;
    while (busy && cnt < 30) begin cnt++; @(negedge clk); end
    smp_valid = 1'b0;
    check(cnt == 9, "R2 busy length", cnt, 9);
    push(0, hdr(0, evt_cnt, 1)); push(0, chg(10));
    push(1, hdr(1, evt_cnt, 1)); push(1, chg(15));
    evt_cnt++;
    drain(0, "R2 ch0"); drain(1, "R2 ch1");

    // R8: one 8-sample waveform record leaves too little room for another
    run_event(8, 1, 0, 0, 0, 0, 0, 10, 1, 0, 1'b1);
    check(busy == 1'b1, "R8 busy held when full", busy, 1);
    run_event(8, 1, 0, 0, 0, 0, 0, 90, 2, 0, 1'b0);
    check(busy == 1'b1, "R8 still busy after refused trigger", busy, 1);
    drain(0, "R8 ch0 single record");
    check(busy == 1'b1, "R8 busy while ch1 full", busy, 1);
    drain(1, "R8 ch1 single record");
    @(negedge clk);
    check(busy == 1'b0, "R8 busy released", busy, 0);

    // R9 R7 R11: three queued events, threshold at and above ch0 charge (20)
    run_event(2, 0, 0, 0,  0, 0, 0, 10, 0, 0, 1'b1);
    run_event(2, 0, 0, 1, 20, 0, 0, 10, 0, 0, 1'b1);
    run_event(2, 0, 0, 1, 21, 0, 0, 10, 0, 0, 1'b1);
    drain(0, "R9 R7 R11 queued ch0");
    drain(1, "R9 R7 R11 queued ch1");
    check(out_valid == '0, "R9 buffers empty", out_valid, 0);

    finish_run();
  end
endmodule